// File: doc/BRIEF.md
# Serial Flash Identification Reader

This block is a serial-peripheral master that reads the identification signature of an attached flash device. A one-cycle `start` pulse opens a frame: chip select goes low, the read-identification opcode is shifted out, and four filler bytes of 0xFF are sent so that four response bytes can be clocked back in. Each response byte lands in its own output register. A match flag reports whether the first response byte equals the expected manufacturer code.

The serial clock is derived from the system clock by a programmable divider, so the bus can be slowed below the attached device's limit. After each frame, chip select stays high for a fixed minimum deselect time before another frame may open. A second, generic port exchanges single bytes full-duplex. It can keep chip select low between bytes, which lets a host send a command followed by a 24-bit address (high byte first) inside one frame.

Top module: `spi_sig_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `busy`, `done`, `xchg_done` and `id_match` are 0, and the four identification registers read 0x00.
- R2: An identification frame keeps `cs_n` low from its first to its last bit. It sends the opcode (parameter, default 0x9F) followed by four 0xFF bytes, which is 40 rising `sck` edges per frame. `cs_n` is low only while `busy` is 1.
- R3: The bus uses mode 0. `sck` is low whenever `cs_n` is high. Every byte is sent MSB first. `mosi` only changes while `sck` is low, so it is stable at each rising edge. `miso` is sampled on the rising edge.
- R4: The four bytes received after the opcode are stored in this order: `mfr_id`, `dev_id1`, `dev_id2`, `ext_id`. Each is assembled MSB first.
- R5: At the end of an identification frame, `id_match` becomes 1 if `mfr_id` equals 0x1F (parameter) and 0 otherwise.
- R6: `done` is high for exactly one system cycle, in the same cycle that `cs_n` returns high at the end of an identification frame.
- R7: Each half period of `sck` lasts `clk_div`+1 system cycles, so `clk_div` = 0 gives the fastest rate, half the system clock.
- R8: After `cs_n` rises, it does not fall again for at least GAP_CYC system cycles (default 200, which is 1 µs at 200 MHz). `busy` stays 1 throughout this gap.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored. This covers both the middle of a frame and the deselect gap. It opens no frame, and no frame is left pending once `busy` drops.
- R10: `xchg_start` sends `xchg_tx` MSB first. When the byte completes, it pulses `xchg_done` and presents the received byte on `xchg_rx`. If both `start` and `xchg_start` arrive while idle, the identification read wins.
- R11: An exchange with `xchg_keep` = 1 leaves `cs_n` low after the byte and waits for the next `xchg_start`. An exchange with `xchg_keep` = 0 closes the frame and enters the deselect gap. A multi-byte command therefore shows a single `cs_n` fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse that opens an identification read |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system cycles |
| xchg_start | input | 1 | Pulse that starts a generic byte exchange |
| xchg_tx | input | 8 | Byte to send in a generic exchange |
| xchg_keep | input | 1 | Keep chip select low after this exchange |
| miso | input | 1 | Serial data from the device |
| busy | output | 1 | Frame active, waiting for the next byte, or in the deselect gap |
| done | output | 1 | One-cycle pulse when an identification read finishes |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| cs_n | output | 1 | Active-low chip select |
| mfr_id | output | 8 | Manufacturer byte |
| dev_id1 | output | 8 | First device byte |
| dev_id2 | output | 8 | Second device byte |
| ext_id | output | 8 | Extended device byte |
| id_match | output | 1 | Manufacturer byte equals the expected value |
| xchg_done | output | 1 | One-cycle pulse when a generic exchange finishes |
| xchg_rx | output | 8 | Byte received in the last generic exchange |

## Verification
The assertions check the following on every cycle:
- `mosi` is stable at each rising `sck` edge.
- `sck` rests low while deselected.
- `cs_n` is low only while `busy` is 1.
- `done` is a single-cycle pulse that coincides with the rise of `cs_n`.
- The deselect gap is counted out before any fall of `cs_n`.
- A `start` pulse during the gap leaves `cs_n` high.

Other behaviours can only be shown by the bench's scenarios, using a device model that records `mosi` and plays back chosen responses:
- the exact bytes on the wire and the order in which responses are stored;
- the match decision;
- the measured `sck` half period for several divider values;
- the framing of a four-byte command with an address.

// File: rtl/spi_sig_pkg.sv
package spi_sig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD,
    ST_GAP
  } seq_st_t;

  // Byte sent at position idx of an identification frame
  function automatic logic [7:0] id_tx_byte(input logic [2:0] idx, input logic [7:0] op);
    return (idx == 3'd0) ? op : 8'hFF;
  endfunction

  function automatic logic mfr_matches(input logic [7:0] got, input logic [7:0] want);
    return got == want;
  endfunction

endpackage

// File: rtl/spi_sck_tick.sv
module spi_sck_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  // tick marks the end of one sck half period
  assign tick = en && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] tx,
  input  logic       tick,
  input  logic       miso,
  output logic       active,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx
);

  logic [7:0] txr;
  logic [7:0] rxr;
  logic [2:0] bitc;
  logic       last_fall;

  assign last_fall = active && tick && sck && (bitc == 3'd7);
  assign mosi      = active ? txr[7] : 1'b1;
  assign rx        = rxr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      sck       <= 1'b0;
      txr       <= 8'hFF;
      rxr       <= 8'h00;
      bitc      <= 3'd0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= last_fall;
      if (load) begin
        active <= 1'b1;
        sck    <= 1'b0;
        txr    <= tx;
        bitc   <= 3'd0;
      end else if (active && tick) begin
        if (!sck) begin
          sck <= 1'b1;
          rxr <= {rxr[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitc == 3'd7) begin
            active <= 1'b0;
          end else begin
            bitc <= bitc + 3'd1;
            txr  <= {txr[6:0], 1'b1};
          end
        end
      end
    end
  end

  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(mosi));

  p_sck_rests_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !sck);

endmodule

// File: rtl/spi_sig_seq.sv
module spi_sig_seq
  import spi_sig_pkg::*;
#(
  parameter logic [7:0] OPCODE  = 8'h9F,
  parameter logic [7:0] EXP_MFR = 8'h1F,
  parameter int         GAP_CYC = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       xchg_start,
  input  logic [7:0] xchg_tx,
  input  logic       xchg_keep,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  output logic       load,
  output logic [7:0] tx_byte,
  output logic       cs_n,
  output logic       busy,
  output logic       done,
  output logic       xchg_done,
  output logic [7:0] xchg_rx,
  output logic [7:0] mfr_id,
  output logic [7:0] dev_id1,
  output logic [7:0] dev_id2,
  output logic [7:0] ext_id,
  output logic       id_match
);

  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);
  localparam logic [GW-1:0] GAP_FULL = GW'(GAP_CYC);

  seq_st_t    st;
  logic       is_id;
  logic       keep_q;
  logic [2:0] idx;
  logic [2:0] idx_nxt;
  logic [GW-1:0] gcnt;
  logic       id_last;

  assign idx_nxt = idx + 3'd1;
  assign id_last = (idx == 3'd4);
  assign busy    = (st != ST_IDLE);

  always_comb begin
    load    = 1'b0;
    tx_byte = xchg_tx;
    unique case (st)
      ST_IDLE: begin
        load    = start || xchg_start;
        tx_byte = start ? id_tx_byte(3'd0, OPCODE) : xchg_tx;
      end
      ST_RUN: begin
        load    = byte_done && is_id && !id_last;
        tx_byte = id_tx_byte(idx_nxt, OPCODE);
      end
      ST_HOLD: begin
        load    = xchg_start;
        tx_byte = xchg_tx;
      end
      default: begin
        load    = 1'b0;
        tx_byte = xchg_tx;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      is_id     <= 1'b0;
      keep_q    <= 1'b0;
      idx       <= 3'd0;
      gcnt      <= '0;
      cs_n      <= 1'b1;
      done      <= 1'b0;
      xchg_done <= 1'b0;
      xchg_rx   <= 8'h00;
      mfr_id    <= 8'h00;
      dev_id1   <= 8'h00;
      dev_id2   <= 8'h00;
      ext_id    <= 8'h00;
      id_match  <= 1'b0;
    end else begin
      done      <= 1'b0;
      xchg_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st    <= ST_RUN;
            is_id <= 1'b1;
            idx   <= 3'd0;
            cs_n  <= 1'b0;
          end else if (xchg_start) begin
            st     <= ST_RUN;
            is_id  <= 1'b0;
            keep_q <= xchg_keep;
            cs_n   <= 1'b0;
          end
        end
        ST_RUN: begin
          if (byte_done) begin
            if (is_id) begin
              unique case (idx)
                3'd1:    mfr_id  <= rx_byte;
                3'd2:    dev_id1 <= rx_byte;
                3'd3:    dev_id2 <= rx_byte;
                3'd4:    ext_id  <= rx_byte;
                default: ;
              endcase
              if (id_last) begin
                st       <= ST_GAP;
                cs_n     <= 1'b1;
                done     <= 1'b1;
                gcnt     <= '0;
                id_match <= mfr_matches(mfr_id, EXP_MFR);
              end else begin
                idx <= idx_nxt;
              end
            end else begin
              xchg_rx   <= rx_byte;
              xchg_done <= 1'b1;
              if (keep_q) begin
                st <= ST_HOLD;
              end else begin
                st   <= ST_GAP;
                cs_n <= 1'b1;
                gcnt <= '0;
              end
            end
          end
        end
        ST_HOLD: begin
          if (xchg_start) begin
            st     <= ST_RUN;
            keep_q <= xchg_keep;
          end
        end
        default: begin
          if (gcnt == GAP_LAST) st <= ST_IDLE;
          else                  gcnt <= gcnt + 1'b1;
        end
      endcase
    end
  end

  // Cycles cs_n has been high, saturating; starts full after reset
  logic [GW-1:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hi_cnt <= GAP_FULL;
    else if (!cs_n)             hi_cnt <= '0;
    else if (hi_cnt < GAP_FULL) hi_cnt <= hi_cnt + 1'b1;
  end

  p_gap_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(hi_cnt) >= GAP_FULL));

  p_done_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_cs_within_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  p_gap_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP && start) |=> cs_n);

endmodule

// File: rtl/spi_sig_reader.sv
module spi_sig_reader #(
  parameter int         DIV_W   = 8,
  parameter logic [7:0] OPCODE  = 8'h9F,
  parameter logic [7:0] EXP_MFR = 8'h1F,
  parameter int         GAP_CYC = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             xchg_start,
  input  logic [7:0]       xchg_tx,
  input  logic             xchg_keep,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic             sck,
  output logic             mosi,
  output logic             cs_n,
  output logic [7:0]       mfr_id,
  output logic [7:0]       dev_id1,
  output logic [7:0]       dev_id2,
  output logic [7:0]       ext_id,
  output logic             id_match,
  output logic             xchg_done,
  output logic [7:0]       xchg_rx
);

  // Named internal events shared between the pieces
  logic       eng_load;
  logic [7:0] eng_tx;
  logic       eng_active;
  logic       eng_tick;
  logic       eng_byte_done;
  logic [7:0] eng_rx;

  spi_sck_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (eng_active),
    .div  (clk_div),
    .tick (eng_tick)
  );

  spi_byte_engine u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (eng_load),
    .tx       (eng_tx),
    .tick     (eng_tick),
    .miso     (miso),
    .active   (eng_active),
    .sck      (sck),
    .mosi     (mosi),
    .byte_done(eng_byte_done),
    .rx       (eng_rx)
  );

  spi_sig_seq #(
    .OPCODE (OPCODE),
    .EXP_MFR(EXP_MFR),
    .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .xchg_start(xchg_start),
    .xchg_tx   (xchg_tx),
    .xchg_keep (xchg_keep),
    .byte_done (eng_byte_done),
    .rx_byte   (eng_rx),
    .load      (eng_load),
    .tx_byte   (eng_tx),
    .cs_n      (cs_n),
    .busy      (busy),
    .done      (done),
    .xchg_done (xchg_done),
    .xchg_rx   (xchg_rx),
    .mfr_id    (mfr_id),
    .dev_id1   (dev_id1),
    .dev_id2   (dev_id2),
    .ext_id    (ext_id),
    .id_match  (id_match)
  );

  p_sck_low_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  p_shift_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_active |-> !cs_n);

endmodule

// File: tb/tb_spi_sig_reader.sv
`timescale 1ns/1ps
module tb_spi_sig_reader;

  localparam int GAP = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] clk_div = 8'd0;
  logic       xchg_start = 1'b0;
  logic [7:0] xchg_tx = 8'h00;
  logic       xchg_keep = 1'b0;
  logic       miso;
  logic       busy, done, sck, mosi, cs_n, id_match, xchg_done;
  logic [7:0] mfr_id, dev_id1, dev_id2, ext_id, xchg_rx;

  spi_sig_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div),
    .xchg_start(xchg_start), .xchg_tx(xchg_tx), .xchg_keep(xchg_keep),
    .miso(miso), .busy(busy), .done(done), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .mfr_id(mfr_id), .dev_id1(dev_id1), .dev_id2(dev_id2),
    .ext_id(ext_id), .id_match(id_match), .xchg_done(xchg_done),
    .xchg_rx(xchg_rx)
  );

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // Device model: records mosi, replays sl_resp on miso
  logic [7:0] sl_resp [0:7];
  logic [7:0] sl_mosi [0:7];
  logic [7:0] rise_cnt = 8'd0;
  int cs_falls = 0;
  int t_rise0 = 0, t_rise1 = 0;
  int t_cs_up = 0;
  int last_gap = 0;

  assign miso = cs_n ? 1'b1 : sl_resp[rise_cnt[5:3]][3'd7 - rise_cnt[2:0]];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge cs_n) begin
    rise_cnt = 8'd0;
    cs_falls++;
    last_gap = cyc - t_cs_up;
  end

  always @(posedge cs_n) t_cs_up = cyc;

  always @(posedge sck) begin
    if (!cs_n) begin
      sl_mosi[rise_cnt[5:3]][3'd7 - rise_cnt[2:0]] = mosi;
      if (rise_cnt == 8'd0) t_rise0 = cyc;
      if (rise_cnt == 8'd1) t_rise1 = cyc;
      rise_cnt = rise_cnt + 8'd1;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "cs_n", cs_n, 1);
    check("R1", "sck", sck, 0);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "xchg_done", xchg_done, 0);
    check("R1", "id_match", id_match, 0);
    check("R1", "ids", {mfr_id, dev_id1, dev_id2, ext_id}, 0);
  endtask

  // Full identification read; optional start pulse in mid-frame (R9)
  task automatic t_id_read(input logic [7:0] div, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input bit poke);
    bit seen;
    int falls0;
    clk_div = div;
    sl_resp[0] = 8'hA5; sl_resp[1] = b0; sl_resp[2] = b1;
    sl_resp[3] = b2;    sl_resp[4] = b3;
    falls0 = cs_falls;
    pulse_start();
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1; @(negedge clk) start = 1'b0;
    end
    wait_done(seen);
    check("R6", "done seen", seen, 1);
    check("R6", "cs_n high with done", cs_n, 1);
    check("R2", "rising edges in frame", rise_cnt, 40);
    check("R2", "cs falls in frame", cs_falls - falls0, 1);
    check("R2", "opcode on mosi", sl_mosi[0], 8'h9F);
    for (int k = 1; k < 5; k++) check("R2", "filler byte", sl_mosi[k], 8'hFF);
    check("R4", "mfr_id", mfr_id, b0);
    check("R4", "dev_id1", dev_id1, b1);
    check("R4", "dev_id2", dev_id2, b2);
    check("R4", "ext_id", ext_id, b3);
    check("R5", "id_match", id_match, (b0 == 8'h1F));
    check("R7", "sck period cycles", t_rise1 - t_rise0, 2 * (div + 1));
    check("R8", "busy in gap", busy, 1);
    @(negedge clk);
    check("R6", "done one cycle", done, 0);
    if (poke) check("R9", "mid-frame start no extra frame", cs_falls - falls0, 1);
  endtask

  // Start during the deselect gap is ignored; back-to-back gap honoured
  task automatic t_gap();
    bit seen;
    int falls0;
    clk_div = 8'd0;
    pulse_start();
    wait_done(seen);
    falls0 = cs_falls;
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (30) @(negedge clk);
    check("R9", "cs_n after gap start", cs_n, 1);
    check("R3", "sck low while deselected", sck, 0);
    wait_idle();
    repeat (5) @(negedge clk);
    check("R9", "no pending frame", cs_falls - falls0, 0);
    check("R9", "busy low", busy, 0);
    // immediate retry: press start every cycle until it is taken
    pulse_start();
    wait_done(seen);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk) start = 1'b1;
      if (!cs_n) break;
    end
    start = 1'b0;
    check("R8", "gap at least GAP_CYC", (last_gap >= GAP) ? 1 : 0, 1);
    wait_done(seen);
    wait_idle();
  endtask

  task automatic xchg_byte(input logic [7:0] b, input bit keep, output logic [7:0] got);
    xchg_tx = b; xchg_keep = keep;
    @(negedge clk) xchg_start = 1'b1;
    @(negedge clk) xchg_start = 1'b0;
    got = 8'h00;
    for (int i = 0; i < 5000; i++) begin
      if (xchg_done) begin got = xchg_rx; break; end
      @(negedge clk);
    end
  endtask

  // Command plus 24-bit address in one frame, high address byte first
  task automatic t_xchg();
    logic [7:0] got;
    logic [23:0] addr;
    int falls0;
    addr = 24'h123456;
    clk_div = 8'd1;
    sl_resp[0] = 8'h11; sl_resp[1] = 8'h22; sl_resp[2] = 8'h33; sl_resp[3] = 8'hC4;
    falls0 = cs_falls;
    xchg_byte(8'h03, 1'b1, got);
    check("R10", "rx byte 0", got, 8'h11);
    check("R11", "cs held after keep", cs_n, 0);
    xchg_byte(addr[23:16], 1'b1, got);
    check("R10", "rx byte 1", got, 8'h22);
    xchg_byte(addr[15:8], 1'b1, got);
    check("R10", "rx byte 2", got, 8'h33);
    check("R11", "cs still held", cs_n, 0);
    xchg_byte(addr[7:0], 1'b0, got);
    check("R10", "rx byte 3", got, 8'hC4);
    check("R11", "cs released on last", cs_n, 1);
    check("R11", "single cs fall", cs_falls - falls0, 1);
    check("R10", "sent cmd", sl_mosi[0], 8'h03);
    check("R11", "addr high first", sl_mosi[1], 8'h12);
    check("R11", "addr mid", sl_mosi[2], 8'h34);
    check("R11", "addr low last", sl_mosi[3], 8'h56);
    check("R10", "no done pulse", done, 0);
    wait_idle();
    // simultaneous request: identification read wins
    sl_resp[1] = 8'h1F;
    @(negedge clk) begin start = 1'b1; xchg_start = 1'b1; xchg_tx = 8'h00; end
    @(negedge clk) begin start = 1'b0; xchg_start = 1'b0; end
    begin
      bit seen;
      wait_done(seen);
      check("R10", "start wins over exchange", seen, 1);
      check("R10", "opcode sent", sl_mosi[0], 8'h9F);
    end
    wait_idle();
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin sl_resp[k] = 8'hFF; sl_mosi[k] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_id_read(8'd0, 8'h1F, 8'h84, 8'h01, 8'h00, 1'b0);
    wait_idle();
    t_id_read(8'd3, 8'hC2, 8'h20, 8'h17, 8'h5A, 1'b1);
    wait_idle();
    t_id_read(8'd2, 8'h1F, 8'h80, 8'h7E, 8'h81, 1'b0);
    wait_idle();
    t_gap();
    t_xchg();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule